// File: doc/BRIEF.md
# Dual-Channel Power-Good Reset Sequencer

This block orders the start-up of two supply channels and produces their active-low reset outputs. Each channel supplies an ideal power-good flag. A built-in counter holds each reset low for a loadable number of clock cycles after its flag rises. A 2-bit mode input picks one of three sequencing schemes. The scheme sets whether channel 2 waits for channel 1, whether the two resets act alone or as one, and which reset state arms the watchdog.

A global enable gates the whole sequence. When it is low, every timer is cleared, both resets are driven low, and the channel-2 start and watchdog-arm outputs are withdrawn. The mode input is meant to be static while the enable is high.

Top module: `por_seq_top`

## Requirements
- R1: In HIGH mode (`mode` = 2'b01), `rst1_n` depends only on `pg1` and `dly1`, and `rst2_n` depends only on `pg2` and `dly2`.
- R2: With delay D, a reset rises on the (D+1)th rising clock edge at which its qualifying flag has been sampled high without a break.
- R3: In HIGH and LOW modes, `ch2_start` equals `en & pg1`.
- R4: In LOW mode (`mode` = 2'b00), both resets stay low until `pg1` and `pg2` are both high and the channel-1 delay `dly1` has run. The channel-1 delay is counted from the cycle both flags are high. Both resets then rise together.
- R5: In HIGH and LOW modes, `wd_arm` is high only when both `rst1_n` and `rst2_n` are high.
- R6: In FLOAT mode (`mode` = 2'b10), `ch2_start` equals `en`. Each reset follows its own flag and delay, and `wd_arm` equals `rst1_n`.
- R7: If a qualifying flag falls, the reset that depends on it goes low in the same cycle without waiting for a clock edge. Its timer restarts from zero on the next rise of the flag.
- R8: While `en` is low, all four outputs are low. On the next clock edge the timers clear, so a full delay is needed again after `en` returns high.
- R9: A delay of zero releases the reset on the first clock edge at which its flag is sampled high.
- R10: The unused code 2'b11 on `mode` behaves exactly as FLOAT mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| en | input | 1 | Global enable |
| mode | input | 2 | Sequencing mode: 00 LOW, 01 HIGH, 10 or 11 FLOAT |
| pg1 | input | 1 | Channel-1 power-good flag |
| pg2 | input | 1 | Channel-2 power-good flag |
| dly1 | input | 20 | Channel-1 hold-off delay in cycles |
| dly2 | input | 20 | Channel-2 hold-off delay in cycles |
| ch2_start | output | 1 | Start request for channel 2 |
| rst1_n | output | 1 | Active-low reset for channel 1 |
| rst2_n | output | 1 | Active-low reset for channel 2 |
| wd_arm | output | 1 | Watchdog start |

## Verification
A timer that holds a wrong count shows up as a reset that rises one or more edges early or late. The bench catches this by checking each reset one edge before and exactly at the expected release edge. A done flag left set after a flag drop, a disable, or a mode change would let a reset rise at once on the next flag rise. This error is visible within the first cycle after the flag rises. Errors in the mode map show up at once on `ch2_start` and `wd_arm`, because both are combinational functions of the resets and flags.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_LOW   = 2'b00,
      SEQ_HIGH  = 2'b01,
      SEQ_FLOAT = 2'b10,
      SEQ_SPARE = 2'b11
   } seq_mode_e;

   localparam int unsigned SEQ_NUM_CH = 2;

endpackage

// File: rtl/por_hold_timer.sv
module por_hold_timer #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qual_i,
   input  logic [CNT_W-1:0] dly_i,
   output logic             rel_o
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("por_hold_timer: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!qual_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q >= dly_i) done_q <= 1'b1;
         else                cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign rel_o = done_q & qual_i;

   // R2
   rel_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rel_o) |-> $past(qual_i));

   // R7
   drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_i |=> !done_q);

endmodule

// File: rtl/por_mode_map.sv
module por_mode_map
   import por_seq_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       en_i,
   input  logic       pg1_i,
   input  logic       pg2_i,
   input  logic [1:0] rel_i,
   output logic [1:0] qual_o,
   output logic       rst1_n_o,
   output logic       rst2_n_o,
   output logic       ch2_start_o,
   output logic       wd_arm_o
);

   logic combined;
   logic gated;

   always_comb begin
      combined = (seq_mode_e'(mode_i) == SEQ_LOW);
      gated    = (seq_mode_e'(mode_i) == SEQ_LOW) || (seq_mode_e'(mode_i) == SEQ_HIGH);

      if (combined) begin
         qual_o[0] = en_i & pg1_i & pg2_i;
         qual_o[1] = 1'b0;
         rst1_n_o  = rel_i[0];
         rst2_n_o  = rel_i[0];
      end else begin
         qual_o[0] = en_i & pg1_i;
         qual_o[1] = en_i & pg2_i;
         rst1_n_o  = rel_i[0];
         rst2_n_o  = rel_i[1];
      end

      if (gated) begin
         ch2_start_o = en_i & pg1_i;
         wd_arm_o    = rst1_n_o & rst2_n_o;
      end else begin
         ch2_start_o = en_i;
         wd_arm_o    = rst1_n_o;
      end
   end

endmodule

// File: rtl/por_seq_top.sv
module por_seq_top
   import por_seq_pkg::*;
#(
   parameter int unsigned DLY_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       mode,
   input  logic             pg1,
   input  logic             pg2,
   input  logic [DLY_W-1:0] dly1,
   input  logic [DLY_W-1:0] dly2,
   output logic             ch2_start,
   output logic             rst1_n,
   output logic             rst2_n,
   output logic             wd_arm
);

   localparam int unsigned NCH = SEQ_NUM_CH;

   if (NCH != 2) begin : g_bad_nch
      $error("por_seq_top: exactly two channels supported");
   end

   logic [NCH-1:0]       qual;
   logic [NCH-1:0]       rel;
   logic [DLY_W-1:0]     dly_arr [NCH];

   assign dly_arr[0] = dly1;
   assign dly_arr[1] = dly2;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      por_hold_timer #(.CNT_W(DLY_W)) i_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .qual_i (qual[c]),
         .dly_i  (dly_arr[c]),
         .rel_o  (rel[c])
      );
   end

   por_mode_map i_map (
      .mode_i      (mode),
      .en_i        (en),
      .pg1_i       (pg1),
      .pg2_i       (pg2),
      .rel_i       (rel),
      .qual_o      (qual),
      .rst1_n_o    (rst1_n),
      .rst2_n_o    (rst2_n),
      .ch2_start_o (ch2_start),
      .wd_arm_o    (wd_arm)
   );

   // R8
   en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!rst1_n && !rst2_n && !ch2_start && !wd_arm));

   // R3
   ch2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] == 1'b0 && !pg1) |-> !ch2_start);

   // R5
   wd_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] == 1'b0 && wd_arm) |-> (rst1_n && rst2_n));

   // R4
   low_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> (rst1_n == rst2_n));

   // R1
   own_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && rst2_n) |-> pg2);

endmodule

// File: tb/test_por_seq_top.sv
module test_por_seq_top;

   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  mode = 2'b01;
   logic        pg1 = 1'b0;
   logic        pg2 = 1'b0;
   logic [19:0] dly1 = '0;
   logic [19:0] dly2 = '0;
   logic        ch2_start, rst1_n, rst2_n, wd_arm;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   por_seq_top i_por_seq_top (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
      .pg1(pg1), .pg2(pg2), .dly1(dly1), .dly2(dly2),
      .ch2_start(ch2_start), .rst1_n(rst1_n), .rst2_n(rst2_n), .wd_arm(wd_arm)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic restart(input logic [1:0] m);
      en = 1'b0; pg1 = 1'b0; pg2 = 1'b0;
      edges(1);
      mode = m; en = 1'b1;
      edges(1);
   endtask

   task automatic t_reset;
      check("R8 reset rst1_n", rst1_n, 1'b0);
      check("R8 reset rst2_n", rst2_n, 1'b0);
      check("R8 reset ch2_start", ch2_start, 1'b0);
      check("R8 reset wd_arm", wd_arm, 1'b0);
   endtask

   task automatic t_high;
      restart(2'b01);
      dly1 = 20'd5; dly2 = 20'd3;
      #1 check("R3 ch2 waits pg1", ch2_start, 1'b0);
      pg1 = 1'b1;
      #1 check("R3 ch2 follows pg1", ch2_start, 1'b1);
      edges(5);
      check("R2 rst1 held at D", rst1_n, 1'b0);
      edges(1);
      check("R2 rst1 released D+1", rst1_n, 1'b1);
      check("R1 rst2 independent", rst2_n, 1'b0);
      check("R5 wd needs both", wd_arm, 1'b0);
      pg2 = 1'b1;
      edges(3);
      check("R2 rst2 held at D", rst2_n, 1'b0);
      edges(1);
      check("R2 rst2 released D+1", rst2_n, 1'b1);
      check("R5 wd armed", wd_arm, 1'b1);
      pg1 = 1'b0;
      #1 check("R7 rst1 drops at once", rst1_n, 1'b0);
      check("R1 rst2 unaffected", rst2_n, 1'b1);
      check("R3 ch2 withdrawn", ch2_start, 1'b0);
      edges(2);
      pg1 = 1'b1;
      edges(5);
      check("R7 timer restarted", rst1_n, 1'b0);
      edges(1);
      check("R7 release after restart", rst1_n, 1'b1);
   endtask

   task automatic t_low;
      restart(2'b00);
      dly1 = 20'd4; dly2 = 20'd0;
      pg1 = 1'b1;
      edges(8);
      check("R4 rst1 waits pg2", rst1_n, 1'b0);
      check("R4 rst2 waits pg2", rst2_n, 1'b0);
      check("R3 ch2 low mode", ch2_start, 1'b1);
      pg2 = 1'b1;
      edges(4);
      check("R4 held at D", rst1_n, 1'b0);
      edges(1);
      check("R4 rst1 together", rst1_n, 1'b1);
      check("R4 rst2 together", rst2_n, 1'b1);
      check("R5 wd low mode", wd_arm, 1'b1);
      pg2 = 1'b0;
      #1 check("R7 low drop rst1", rst1_n, 1'b0);
      check("R7 low drop rst2", rst2_n, 1'b0);
      check("R5 wd drops", wd_arm, 1'b0);
   endtask

   task automatic t_float(input logic [1:0] m, input string tag);
      restart(m);
      dly1 = 20'd2; dly2 = 20'd7;
      #1 check({tag, " ch2 immediate"}, ch2_start, 1'b1);
      pg1 = 1'b1;
      edges(2);
      check({tag, " rst1 held"}, rst1_n, 1'b0);
      edges(1);
      check({tag, " rst1 released"}, rst1_n, 1'b1);
      check({tag, " wd follows rst1"}, wd_arm, 1'b1);
      check({tag, " rst2 own flag"}, rst2_n, 1'b0);
   endtask

   task automatic t_zero;
      restart(2'b01);
      dly1 = 20'd0;
      pg1 = 1'b1;
      #1 check("R9 before edge", rst1_n, 1'b0);
      edges(1);
      check("R9 first edge release", rst1_n, 1'b1);
   endtask

   task automatic t_enable;
      restart(2'b01);
      dly1 = 20'd3; dly2 = 20'd1;
      pg1 = 1'b1; pg2 = 1'b1;
      edges(4);
      check("R8 setup released", wd_arm, 1'b1);
      en = 1'b0;
      #1 check("R8 rst1 off", rst1_n, 1'b0);
      check("R8 ch2 off", ch2_start, 1'b0);
      check("R8 wd off", wd_arm, 1'b0);
      edges(1);
      en = 1'b1;
      edges(3);
      check("R8 timer cleared", rst1_n, 1'b0);
      edges(1);
      check("R8 full delay again", rst1_n, 1'b1);
   endtask

   task automatic t_long;
      restart(2'b01);
      dly1 = 20'd1000;
      pg1 = 1'b1;
      edges(1000);
      check("R2 long held", rst1_n, 1'b0);
      edges(1);
      check("R2 long released", rst1_n, 1'b1);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected finish");
         summary();
      end
   end

   initial begin
      edges(2);
      rst_n = 1'b1;
      edges(1);
      t_reset();
      t_high();
      t_low();
      t_float(2'b10, "R6");
      t_float(2'b11, "R10");
      t_zero();
      t_enable();
      t_long();
      finished = 1'b1;
      summary();
   end

endmodule